// File: doc/BRIEF.md
# Multilevel Unidirectional Routing Switch Box

This block is the programmable switch box at each corner of a mesh-of-clusters fabric. Four unidirectional channels meet it, one per side. Each channel has width W: W/2 tracks enter the box and W/2 tracks leave it. Four logic clusters also touch the box. The box collects some of their outputs and drives some of their inputs. Routing passes through three levels of small full crossbars. The side crossbars carry traffic from one switch box to the next. The gather crossbars collect cluster outputs. The drop crossbars feed cluster inputs. Because of this arrangement the fabric needs no separate connection blocks.

Every crossbar output is a multiplexer whose select comes from a configuration register. The register loads through a serial shift chain. Once it is loaded, the box is purely combinational from its data inputs to its data outputs. Reset clears every select to zero. W, the cluster input count and the cluster output count are parameters, and elaboration stops if the per-crossbar counts they imply are not whole numbers.

Top module: `mesh_switch_box`

## Requirements
- R1: After reset every select is zero. Output track k on every side then copies input track k of side 0. Cluster input n of every cluster copies input track n·P3 of side 0, where P3 = 2W/CL_IN.
- R2: While cfg_en_i is high, each clock shifts cfg_d_i into the top bit of the configuration register and moves every bit down by one. cfg_q_o shows bit 0, so the first bit shifted in reaches bit 0 after NCFG shifts, and NCFG further shifts bring it out in load order.
- R3: Side crossbar k drives output track k on side s (index s·W/2+k, sides 0 to 3). Its 3-bit select sits at bit (k·5+s)·3. Codes 0 to 3 pick input track k of that side, and code 4 picks gather output k.
- R4: Side crossbar select codes 5, 6 and 7 drive logic 0.
- R5: Gather crossbar m (m < CL_OUT/4) output q feeds side crossbar m·P2+q through input code 4, where P2 = 2W/CL_OUT. Its 2-bit select, at bit L1B + (m·P2+q)·2 with L1B = (W/2)·15, picks output m of cluster c (clo_i index c·CL_OUT/4+m).
- R6: Side crossbar k has a fifth output, selected at bit (k·5+4)·3 with the codes of R3 and R4, and it feeds drop input k. Drop crossbar n drives input n of cluster c (cli_o index c·CL_IN/4+n) from drop input n·P3+v. Here v is its select at bit L1B+L2B+(n·4+c)·S3, with L2B = (CL_OUT/4)·P2·2 and S3 = max(1, clog2 P3).
- R7: A cluster output can reach a cluster input through the gather, side and drop levels with no clock edge in between.
- R8: While cfg_en_i is low the configuration holds whatever cfg_d_i does, and the outputs change only when the data inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears configuration |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_d_i | input | 1 | Serial configuration data in |
| cfg_q_o | output | 1 | Serial configuration data out (bit 0) |
| trk_i | input | 2*W | Incoming tracks, side s track k at s*W/2+k |
| trk_o | output | 2*W | Outgoing tracks, same indexing |
| clo_i | input | CL_OUT | Cluster outputs, cluster c output m at c*CL_OUT/4+m |
| cli_o | output | CL_IN | Cluster inputs, cluster c input n at c*CL_IN/4+n |

## Verification
The hardest case to reach from the ports is the full cluster-to-cluster path. The gather, side-fifth-output and drop selects must all agree, and only cli_o shows the result. The bench builds whole configuration images in which one pattern sets all three levels together. It shifts each image in serially, then sweeps the cluster outputs and compares cli_o against a model built from the requirements. Out-of-range side codes are checked the same way, with the inputs all ones, so that a blank output shows up as 0.

// File: rtl/msb_pkg.sv
package msb_pkg;
  localparam int NSIDE = 4;
  localparam int L1_PORTS = 5;

  function automatic int sel_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msb_cfg_chain.sv
module msb_cfg_chain #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         d_i,
  output logic         q_o,
  output logic [N-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (en_i) cfg_o <= {d_i, cfg_o[N-1:1]};
  end

  assign q_o = cfg_o[0];
endmodule

// File: rtl/msb_xbar.sv
module msb_xbar #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int SW    = 2
) (
  input  logic [N_IN-1:0]     in_i,
  input  logic [N_OUT*SW-1:0] sel_i,
  output logic [N_OUT-1:0]    out_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [SW-1:0] s;
    assign s = sel_i[o*SW +: SW];
    if ((1 << SW) > N_IN) begin : g_guard
      // unused codes blank the output
      assign out_o[o] = (int'(s) < N_IN) ? in_i[s] : 1'b0;
    end else begin : g_full
      assign out_o[o] = in_i[s];
    end
  end
endmodule

// File: rtl/mesh_switch_box.sv
module mesh_switch_box
  import msb_pkg::*;
#(
  parameter int W      = 8,
  parameter int CL_IN  = 8,
  parameter int CL_OUT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_d_i,
  output logic              cfg_q_o,
  input  logic [2*W-1:0]    trk_i,
  output logic [2*W-1:0]    trk_o,
  input  logic [CL_OUT-1:0] clo_i,
  output logic [CL_IN-1:0]  cli_o
);
  localparam int HW   = W / 2;
  localparam int Q2   = CL_OUT / NSIDE;
  localparam int P2   = 2 * W / CL_OUT;
  localparam int Q3   = CL_IN / NSIDE;
  localparam int P3   = 2 * W / CL_IN;
  localparam int S1   = sel_w(L1_PORTS);
  localparam int S2   = sel_w(NSIDE);
  localparam int S3   = sel_w(P3);
  localparam int L1B  = HW * L1_PORTS * S1;
  localparam int L2B  = Q2 * P2 * S2;
  localparam int L3B  = Q3 * NSIDE * S3;
  localparam int NCFG = L1B + L2B + L3B;

  if ((W % 2) != 0 || (CL_IN % NSIDE) != 0 || (CL_OUT % NSIDE) != 0 ||
      (2 * W) % CL_IN != 0 || (2 * W) % CL_OUT != 0) begin : g_bad_params
    $error("mesh_switch_box: W, CL_IN and CL_OUT give non-integer crossbar counts");
  end

  logic [NCFG-1:0] cfg;
  logic [HW-1:0]   l2_out;
  logic [HW-1:0]   l1_dn;

  msb_cfg_chain #(.N(NCFG)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_en_i),
    .d_i    (cfg_d_i),
    .q_o    (cfg_q_o),
    .cfg_o  (cfg)
  );

  // level 1: side-to-side, one track per side per crossbar
  for (genvar k = 0; k < HW; k++) begin : g_l1
    logic [L1_PORTS-1:0] l1_in, l1_out;
    assign l1_in = {l2_out[k], trk_i[3*HW+k], trk_i[2*HW+k], trk_i[HW+k], trk_i[k]};
    msb_xbar #(.N_IN(L1_PORTS), .N_OUT(L1_PORTS), .SW(S1)) u_xbar (
      .in_i  (l1_in),
      .sel_i (cfg[k*L1_PORTS*S1 +: L1_PORTS*S1]),
      .out_o (l1_out)
    );
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      assign trk_o[s*HW+k] = l1_out[s];
    end
    assign l1_dn[k] = l1_out[NSIDE];
  end

  // level 2: gather one output of each neighbour cluster
  for (genvar m = 0; m < Q2; m++) begin : g_l2
    logic [NSIDE-1:0] l2_in;
    for (genvar c = 0; c < NSIDE; c++) begin : g_cl
      assign l2_in[c] = clo_i[c*Q2+m];
    end
    msb_xbar #(.N_IN(NSIDE), .N_OUT(P2), .SW(S2)) u_xbar (
      .in_i  (l2_in),
      .sel_i (cfg[L1B + m*P2*S2 +: P2*S2]),
      .out_o (l2_out[m*P2 +: P2])
    );
  end

  // level 3: drop one input into each neighbour cluster
  for (genvar n = 0; n < Q3; n++) begin : g_l3
    logic [NSIDE-1:0] l3_out;
    msb_xbar #(.N_IN(P3), .N_OUT(NSIDE), .SW(S3)) u_xbar (
      .in_i  (l1_dn[n*P3 +: P3]),
      .sel_i (cfg[L1B + L2B + n*NSIDE*S3 +: NSIDE*S3]),
      .out_o (l3_out)
    );
    for (genvar c = 0; c < NSIDE; c++) begin : g_cl
      assign cli_o[c*Q3+n] = l3_out[c];
    end
  end
endmodule

// File: rtl/mesh_switch_box_chk.sv
module mesh_switch_box_chk
  import msb_pkg::*;
#(
  parameter int W      = 8,
  parameter int CL_IN  = 8,
  parameter int CL_OUT = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_en_i,
  input logic                 cfg_q_o,
  input logic [2*W-1:0]       trk_i,
  input logic [2*W-1:0]       trk_o,
  input logic [CL_OUT-1:0]    clo_i,
  input logic [CL_IN-1:0]     cli_o,
  input logic [W/2-1:0]       l2_out,
  input logic [W/2-1:0]       l1_dn,
  input logic [(W/2)*15 + (CL_OUT/4)*(2*W/CL_OUT)*2
               + (CL_IN/4)*4*sel_w(2*W/CL_IN) - 1:0] cfg
);
  localparam int HW  = W / 2;
  localparam int Q2  = CL_OUT / NSIDE;
  localparam int P2  = 2 * W / CL_OUT;
  localparam int Q3  = CL_IN / NSIDE;
  localparam int P3  = 2 * W / CL_IN;
  localparam int S3  = sel_w(P3);
  localparam int L1B = HW * 15;
  localparam int L2B = Q2 * P2 * 2;

  // R2
  chain_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> cfg_q_o == $past(cfg[1]));

  // R8
  chain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_q_o));

  for (genvar k = 0; k < HW; k++) begin : g_l1
    for (genvar s = 0; s < NSIDE; s++) begin : g_s
      logic [2:0] sel;
      assign sel = cfg[(k*5+s)*3 +: 3];
      // R3
      side_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel < 3'd4) |-> trk_o[s*HW+k] == trk_i[int'(sel)*HW+k]);
      // R4
      blank_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel > 3'd4) |-> !trk_o[s*HW+k]);
    end
  end

  for (genvar m = 0; m < Q2; m++) begin : g_l2
    for (genvar q = 0; q < P2; q++) begin : g_q
      logic [1:0] sel;
      assign sel = cfg[L1B + (m*P2+q)*2 +: 2];
      // R5
      gather_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        l2_out[m*P2+q] == clo_i[int'(sel)*Q2+m]);
    end
  end

  for (genvar n = 0; n < Q3; n++) begin : g_l3
    for (genvar c = 0; c < NSIDE; c++) begin : g_c
      logic [S3-1:0] sel;
      assign sel = cfg[L1B + L2B + (n*4+c)*S3 +: S3];
      // R6
      drop_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cli_o[c*Q3+n] == l1_dn[n*P3+int'(sel)]);
    end
  end
endmodule

bind mesh_switch_box mesh_switch_box_chk #(.W(W), .CL_IN(CL_IN), .CL_OUT(CL_OUT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_en_i (cfg_en_i),
  .cfg_q_o  (cfg_q_o),
  .trk_i    (trk_i),
  .trk_o    (trk_o),
  .clo_i    (clo_i),
  .cli_o    (cli_o),
  .l2_out   (l2_out),
  .l1_dn    (l1_dn),
  .cfg      (cfg)
);

// File: tb/sim_mesh_switch_box.sv
module sim_mesh_switch_box;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, CL_IN = 8, CL_OUT = 8;
  localparam int HW = 4, Q2 = 2, P2 = 2, Q3 = 2, P3 = 2;
  localparam int L1B = 60, L2B = 8, NCFG = 76;

  logic clk_i = 1'b0, rst_ni = 1'b1, cfg_en_i = 1'b0, cfg_d_i = 1'b0;
  logic cfg_q_o;
  logic [2*W-1:0] trk_i = '0, trk_o;
  logic [CL_OUT-1:0] clo_i = '0;
  logic [CL_IN-1:0] cli_o;
  logic [NCFG-1:0] img;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mesh_switch_box #(.W(W), .CL_IN(CL_IN), .CL_OUT(CL_OUT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_d_i(cfg_d_i),
    .cfg_q_o(cfg_q_o), .trk_i(trk_i), .trk_o(trk_o), .clo_i(clo_i), .cli_o(cli_o));

  // reference model from the requirements
  function automatic logic gather(int j);
    int m = j / P2, q = j % P2;
    int c = int'(img[L1B + (m*P2+q)*2 +: 2]);
    return clo_i[c*Q2+m];
  endfunction

  function automatic logic side(int k, int o);
    int v = int'(img[(k*5+o)*3 +: 3]);
    if (v < 4) return trk_i[v*HW+k];
    if (v == 4) return gather(k);
    return 1'b0;
  endfunction

  function automatic logic [2*W-1:0] exp_trk();
    logic [2*W-1:0] r;
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < HW; k++) r[s*HW+k] = side(k, s);
    return r;
  endfunction

  function automatic logic [CL_IN-1:0] exp_cli();
    logic [CL_IN-1:0] r;
    for (int n = 0; n < Q3; n++)
      for (int c = 0; c < 4; c++)
        r[c*Q3+n] = side(n*P3 + int'(img[L1B + L2B + (n*4+c)]), 4);
    return r;
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_outputs(string tag);
    check(tag, "trk_o", 32'(trk_o), 32'(exp_trk()));
    check(tag, "cli_o", 32'(cli_o), 32'(exp_cli()));
  endtask

  task automatic sweep(string tag, int vectors);
    for (int i = 0; i < vectors; i++) begin
      @(negedge clk_i);
      trk_i = 16'($urandom);
      clo_i = 8'($urandom);
      #1 compare_outputs(tag);
    end
  endtask

  task automatic load_image();
    for (int i = 0; i < NCFG; i++) begin
      @(negedge clk_i);
      cfg_en_i = 1'b1;
      cfg_d_i  = img[i];
    end
    @(negedge clk_i);
    cfg_en_i = 1'b0;
    cfg_d_i  = 1'b0;
  endtask

  task automatic set_l1(int k, int o, int v);
    img[(k*5+o)*3 +: 3] = 3'(v);
  endtask

  task automatic set_l2(int m, int q, int c);
    img[L1B + (m*P2+q)*2 +: 2] = 2'(c);
  endtask

  task automatic set_l3(int n, int c, int v);
    img[L1B + L2B + n*4 + c] = 1'(v);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    img = '0;
    #1 check("R1", "cfg_q_o", 32'(cfg_q_o), 32'd0);
    trk_i = 16'h00f1;
    #1 check("R1", "trk_o", 32'(trk_o), 32'hf1f1 & 32'h0000ffff & {16'h0, {4{4'h1}}});
    check("R1", "cli_o", 32'(cli_o), 32'h55);
    sweep("R1", 6);
  endtask

  task automatic t_chain();
    img = '0;
    for (int i = 0; i < NCFG; i++) img[i] = 1'((i * 7 + 3) % 5 == 0);
    img[0] = 1'b1; img[1] = 1'b0; img[2] = 1'b1; img[3] = 1'b1;
    load_image();
    check("R2", "cfg_q_o bit0", 32'(cfg_q_o), 32'(img[0]));
    for (int i = 1; i < 4; i++) begin
      @(negedge clk_i); cfg_en_i = 1'b1; cfg_d_i = 1'b0;
      @(negedge clk_i); cfg_en_i = 1'b0;
      check("R2", "cfg_q_o shifted", 32'(cfg_q_o), 32'(img[i]));
    end
  endtask

  task automatic t_side_route();
    img = '0;
    for (int k = 0; k < HW; k++)
      for (int o = 0; o < 4; o++) set_l1(k, o, (o + k + 1) % 4);
    load_image();
    sweep("R3", 8);
  endtask

  task automatic t_blank();
    img = '0;
    for (int k = 0; k < HW; k++) begin
      set_l1(k, 0, 5); set_l1(k, 1, 6); set_l1(k, 2, 7); set_l1(k, 3, k % 4);
      set_l1(k, 4, 5 + (k % 3));
    end
    load_image();
    @(negedge clk_i);
    trk_i = '1; clo_i = '1;
    #1 check("R4", "trk_o blanked", 32'(trk_o), 32'hf000);
    check("R4", "cli_o blanked", 32'(cli_o), 32'h00);
    sweep("R4", 4);
  endtask

  task automatic t_gather();
    img = '0;
    for (int k = 0; k < HW; k++)
      for (int o = 0; o < 4; o++) set_l1(k, o, (o == k % 4) ? 4 : o);
    for (int m = 0; m < Q2; m++)
      for (int q = 0; q < P2; q++) set_l2(m, q, (m * 2 + q + 1) % 4);
    load_image();
    sweep("R5", 10);
  endtask

  task automatic t_drop();
    img = '0;
    for (int k = 0; k < HW; k++) set_l1(k, 4, 3 - k);
    for (int n = 0; n < Q3; n++)
      for (int c = 0; c < 4; c++) set_l3(n, c, (n + c) % 2);
    load_image();
    sweep("R6", 10);
  endtask

  task automatic t_cluster_loop();
    img = '0;
    for (int k = 0; k < HW; k++) set_l1(k, 4, 4);
    for (int m = 0; m < Q2; m++)
      for (int q = 0; q < P2; q++) set_l2(m, q, 3 - q - m);
    for (int n = 0; n < Q3; n++)
      for (int c = 0; c < 4; c++) set_l3(n, c, c % 2);
    load_image();
    // directed: only cluster 3 output 0 high
    @(negedge clk_i);
    trk_i = '0; clo_i = 8'h40;
    #1 check("R7", "cli_o single source", 32'(cli_o), 32'(exp_cli()));
    sweep("R7", 10);
  endtask

  task automatic t_hold();
    img = '0;
    for (int k = 0; k < HW; k++)
      for (int o = 0; o < 5; o++) set_l1(k, o, (k + o) % 5);
    for (int m = 0; m < Q2; m++)
      for (int q = 0; q < P2; q++) set_l2(m, q, q + 2*m);
    img[0] = 1'b1;
    load_image();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      cfg_d_i = ~cfg_d_i;
      trk_i = 16'($urandom); clo_i = 8'($urandom);
      #1 compare_outputs("R8");
      check("R8", "cfg_q_o held", 32'(cfg_q_o), 32'(img[0]));
    end
    cfg_d_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_chain();
    t_side_route();
    t_blank();
    t_gather();
    t_drop();
    t_cluster_loop();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule